// File: doc/BRIEF.md
# Neural Accelerator Command Sequencer

This block is the control engine of a neural-network accelerator. Software programs three base addresses (input frame buffer, output buffer, program-and-weights region) and pulses a start bit. From then on the sequencer runs on its own. It reads 32-bit command words from local memory at consecutive word addresses, decodes each one, and hands it to either the DMA port or the compute port. Unless a command asks to run detached, the sequencer waits for that unit's done pulse before it fetches the next command. One start processes exactly one frame. The run ends when a stop command arrives and every outstanding unit has reported done. Completion raises a level interrupt that stays high until software clears it.

Three request paths leave the block: fetch, DMA and compute. Each uses a valid/ready handshake. A request is presented with valid high and, while ready is low, valid and the payload stay constant. The handshake completes on the first rising edge that sees both high. Consumers may apply back-pressure for any number of cycles. Fetch data comes back on a separate one-cycle response strobe. The DMA and compute units each report completion with a one-cycle done pulse, at least one cycle after their handshake.

The status outputs are plain levels: busy, interrupt, error, and the cycle length of the last completed run.

Top module: `nn_cmd_seq`

## Requirements
- R1: After reset, busy, irq and err are 0, no request valid is high, and last_cycles is 0.
- R2: A go sampled while idle makes busy high on the next cycle. The first fetch address is the program base, and each later fetch address is one word above the previous one.
- R3: While dma_valid, cmp_valid or fetch_valid is high and its ready is low, the valid stays high and its payload stays stable.
- R4: A command word is laid out as opcode [31:28], no-wait flag [27], base select [26:25], length [24:16] and offset [15:0]. Opcode 0 is a DMA read and opcode 1 is a DMA write (dma_write=1). A DMA request carries dma_len equal to the length field. Its dma_addr is the offset plus a base chosen by the select field: 0 gives the input base, 1 the output base, 2 the program base, and 3 gives zero.
- R5: Opcodes 2 to 6 are dispatched on the compute port with cmp_kind equal to opcode minus 2: convolution, deconvolution, inner product, shift, element-wise. cmp_arg carries the offset field.
- R6: A command that runs blocking is followed by no fetch until its unit has returned done.
- R7: A DMA read or compute command with the no-wait flag set lets the next fetch start before its done. Any later command for that same unit is not presented until the done arrives. The flag has no effect on a DMA write.
- R8: Stop (opcode 7) waits until both units have no outstanding done. Busy then drops and irq rises. irq stays high until irq_clr is pulsed.
- R9: An opcode from 8 to 15 sets err and drops busy, with no dispatch, no further fetch and no irq. err is cleared by the next accepted go.
- R10: A go pulsed while busy is ignored. The fetch sequence continues unchanged and no second run follows.
- R11: When a run ends on stop, last_cycles equals the number of cycles that busy was high during that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_base | input | AW | Input frame buffer base |
| cfg_out_base | input | AW | Output buffer base |
| cfg_prog_base | input | AW | Program and weights base; the first fetch address |
| go | input | 1 | Start pulse, honoured only while idle |
| irq_clr | input | 1 | Clears the completion interrupt |
| busy | output | 1 | A run is in progress |
| irq | output | 1 | Completion interrupt, held level |
| err | output | 1 | Last run halted on an undefined opcode |
| last_cycles | output | CW | Busy cycles of the last run that ended on stop |
| fetch_valid | output | 1 | Command fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | AW | Command word address |
| fetch_rsp_valid | input | 1 | Fetched word strobe |
| fetch_rsp_data | input | 32 | Fetched command word |
| dma_valid | output | 1 | DMA request |
| dma_ready | input | 1 | DMA request accepted |
| dma_write | output | 1 | 1 = write to memory, 0 = read |
| dma_addr | output | AW | DMA address |
| dma_len | output | 9 | DMA length field |
| dma_done | input | 1 | DMA transfer finished |
| cmp_valid | output | 1 | Compute request |
| cmp_ready | input | 1 | Compute request accepted |
| cmp_kind | output | 3 | Compute operation kind |
| cmp_arg | output | 16 | Compute operand field |
| cmp_done | input | 1 | Compute operation finished |

## Verification
A corrupted program counter shows up at the very next fetch as an address outside the expected word sequence. A mis-decoded command shows up at its own dispatch handshake, where the scoreboard compares unit, address, length and kind. A wrong pending flag shows up within one command: a fetch appears while a blocking unit is still busy, a second request goes to a unit that has not reported done, or busy drops with a done still outstanding. A wrong counter or interrupt state is visible on the cycle the run ends.

// File: rtl/nn_cmd_pkg.sv
package nn_cmd_pkg;
  localparam int CMD_W = 32;
  localparam int LEN_W = 9;
  localparam int OFF_W = 16;
  localparam int KIND_W = 3;

  typedef enum logic [3:0] {
    OP_DMA_RD = 4'd0, OP_DMA_WR = 4'd1, OP_CONV = 4'd2, OP_DECONV = 4'd3,
    OP_INNER = 4'd4, OP_SHIFT = 4'd5, OP_ELTW = 4'd6, OP_STOP = 4'd7
  } opcode_e;

  typedef struct packed {
    logic [3:0]       op;
    logic             nowait;
    logic [1:0]       bsel;
    logic [LEN_W-1:0] len;
    logic [OFF_W-1:0] off;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RSP, S_ISSUE, S_WAIT, S_DRAIN
  } seq_state_e;
endpackage

// File: rtl/nn_cmd_decode.sv
module nn_cmd_decode import nn_cmd_pkg::*; #(
  parameter int AW = 32
) (
  input  cmd_t                cmd,
  input  logic [AW-1:0]       in_base,
  input  logic [AW-1:0]       out_base,
  input  logic [AW-1:0]       prog_base,
  output logic                is_dma,
  output logic                is_cmp,
  output logic                is_stop,
  output logic                illegal,
  output logic                detached,
  output logic                dma_write,
  output logic [AW-1:0]       dma_addr,
  output logic [KIND_W-1:0]   cmp_kind
);
  logic [AW-1:0] base;
  logic [3:0]    kind_full;

  always_comb begin
    case (cmd.bsel)
      2'd0:    base = in_base;
      2'd1:    base = out_base;
      2'd2:    base = prog_base;
      default: base = '0;
    endcase
  end

  assign is_dma    = (cmd.op == OP_DMA_RD) || (cmd.op == OP_DMA_WR);
  assign is_cmp    = (cmd.op >= OP_CONV) && (cmd.op <= OP_ELTW);
  assign is_stop   = (cmd.op == OP_STOP);
  assign illegal   = cmd.op[3];
  assign detached  = cmd.nowait && ((cmd.op == OP_DMA_RD) || is_cmp);
  assign dma_write = (cmd.op == OP_DMA_WR);
  assign dma_addr  = base + AW'(cmd.off);
  assign kind_full = cmd.op - 4'd2;
  assign cmp_kind  = kind_full[KIND_W-1:0];
endmodule

// File: rtl/nn_cmd_fsm.sv
module nn_cmd_fsm import nn_cmd_pkg::*; #(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             irq_clr,
  input  logic [AW-1:0]    prog_base,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [AW-1:0]    fetch_addr,
  input  logic             rsp_valid,
  input  logic [CMD_W-1:0] rsp_data,
  output cmd_t             cmd_q,
  input  logic             is_dma,
  input  logic             is_cmp,
  input  logic             is_stop,
  input  logic             illegal,
  input  logic             detached,
  input  logic [AW-1:0]    dma_addr,
  input  logic             dma_write,
  output logic             dma_valid,
  input  logic             dma_ready,
  input  logic             dma_done,
  output logic             cmp_valid,
  input  logic             cmp_ready,
  input  logic             cmp_done,
  output logic             busy,
  output logic             irq,
  output logic             err,
  output logic             finish
);
  seq_state_e    st, st_n;
  logic [AW-1:0] pc;
  logic          dma_pend, cmp_pend;
  logic          dma_fire, cmp_fire, start, unit_free;

  assign start       = (st == S_IDLE) && go;
  assign busy        = (st != S_IDLE);
  assign fetch_valid = (st == S_FETCH);
  assign fetch_addr  = pc;
  assign dma_valid   = (st == S_ISSUE) && is_dma && !dma_pend;
  assign cmp_valid   = (st == S_ISSUE) && is_cmp && !cmp_pend;
  assign dma_fire    = dma_valid && dma_ready;
  assign cmp_fire    = cmp_valid && cmp_ready;
  assign finish      = (st == S_DRAIN) && !dma_pend && !cmp_pend;
  assign unit_free   = is_dma ? !dma_pend : !cmp_pend;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (go) st_n = S_FETCH;
      S_FETCH: if (fetch_ready) st_n = S_RSP;
      S_RSP:   if (rsp_valid) st_n = S_ISSUE;
      S_ISSUE: begin
        if (illegal)                 st_n = S_IDLE;
        else if (is_stop)            st_n = S_DRAIN;
        else if (dma_fire || cmp_fire) st_n = detached ? S_FETCH : S_WAIT;
      end
      S_WAIT:  if (unit_free) st_n = S_FETCH;
      S_DRAIN: if (finish) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc       <= '0;
      cmd_q    <= '0;
      dma_pend <= 1'b0;
      cmp_pend <= 1'b0;
      irq      <= 1'b0;
      err      <= 1'b0;
    end else begin
      st <= st_n;
      if (start) pc <= prog_base;
      else if (st == S_RSP && rsp_valid) pc <= pc + AW'(1);
      if (st == S_RSP && rsp_valid) cmd_q <= cmd_t'(rsp_data);
      if (dma_fire) dma_pend <= 1'b1;
      else if (dma_done) dma_pend <= 1'b0;
      if (cmp_fire) cmp_pend <= 1'b1;
      else if (cmp_done) cmp_pend <= 1'b0;
      if (finish) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (start) err <= 1'b0;
      else if (st == S_ISSUE && illegal) err <= 1'b1;
    end
  end

  assert_dma_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_write));
  assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmd_q));
  assert_start_needs_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  assert_stop_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !err |-> irq);
  assert_halt_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
endmodule

// File: rtl/nn_cmd_timer.sv
module nn_cmd_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          finish,
  output logic [CW-1:0] last_cycles
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt     <= '0;
      last_cycles <= '0;
    end else begin
      run_cnt <= busy ? run_cnt + CW'(1) : '0;
      if (finish) last_cycles <= run_cnt + CW'(1);
    end
  end

  assert_count_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_cycles) |-> $fell(busy));
endmodule

// File: rtl/nn_cmd_seq.sv
module nn_cmd_seq import nn_cmd_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_in_base,
  input  logic [AW-1:0] cfg_out_base,
  input  logic [AW-1:0] cfg_prog_base,
  input  logic          go,
  input  logic          irq_clr,
  output logic          busy,
  output logic          irq,
  output logic          err,
  output logic [CW-1:0] last_cycles,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_rsp_valid,
  input  logic [31:0]   fetch_rsp_data,
  output logic          dma_valid,
  input  logic          dma_ready,
  output logic          dma_write,
  output logic [AW-1:0] dma_addr,
  output logic [8:0]    dma_len,
  input  logic          dma_done,
  output logic          cmp_valid,
  input  logic          cmp_ready,
  output logic [2:0]    cmp_kind,
  output logic [15:0]   cmp_arg,
  input  logic          cmp_done
);
  cmd_t cmd_q;
  logic is_dma, is_cmp, is_stop, illegal, detached, finish;

  nn_cmd_decode #(.AW(AW)) u_decode (
    .cmd(cmd_q), .in_base(cfg_in_base), .out_base(cfg_out_base),
    .prog_base(cfg_prog_base), .is_dma(is_dma), .is_cmp(is_cmp),
    .is_stop(is_stop), .illegal(illegal), .detached(detached),
    .dma_write(dma_write), .dma_addr(dma_addr), .cmp_kind(cmp_kind)
  );

  nn_cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .irq_clr(irq_clr),
    .prog_base(cfg_prog_base), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rsp_valid(fetch_rsp_valid), .rsp_data(fetch_rsp_data), .cmd_q(cmd_q),
    .is_dma(is_dma), .is_cmp(is_cmp), .is_stop(is_stop), .illegal(illegal),
    .detached(detached), .dma_addr(dma_addr), .dma_write(dma_write),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_done(dma_done),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_done(cmp_done),
    .busy(busy), .irq(irq), .err(err), .finish(finish)
  );

  nn_cmd_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .finish(finish),
    .last_cycles(last_cycles)
  );

  assign dma_len = cmd_q.len;
  assign cmp_arg = cmd_q.off;
endmodule

// File: tb/nn_cmd_seq_bench.sv
module nn_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 24;

  logic clk = 0, rst_n = 0, go = 0, irq_clr = 0;
  logic [AW-1:0] cfg_in_base = 32'h1000_0000, cfg_out_base = 32'h2000_0000;
  logic [AW-1:0] cfg_prog_base = 32'h0000_4000;
  logic busy, irq, err, fetch_valid, dma_valid, dma_write, cmp_valid;
  logic [CW-1:0] last_cycles;
  logic [AW-1:0] fetch_addr, dma_addr;
  logic [8:0] dma_len;
  logic [2:0] cmp_kind;
  logic [15:0] cmp_arg;
  logic fetch_ready = 0, fetch_rsp_valid = 0, dma_ready = 0, dma_done = 0;
  logic cmp_ready = 0, cmp_done = 0;
  logic [31:0] fetch_rsp_data = 0;

  nn_cmd_seq #(.AW(AW), .CW(CW)) u_nn_cmd_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit is_dma; bit wr; logic [31:0] addr; logic [8:0] len;
    logic [2:0] kind; logic [15:0] arg; bit blocking;
  } item_t;
  item_t exp_q[$];

  logic [31:0] prog [0:31];
  int total = 0, failed = 0;
  int fetch_lat = 0, dma_rdy_dly = 0, dma_done_dly = 0, cmp_rdy_dly = 0, cmp_done_dly = 0;
  logic [AW-1:0] exp_fetch;
  int fetch_count = 0;
  bit blk_out = 0, blk_viol = 0, overlap_seen = 0, r7_viol = 0;
  bit d_nw = 0, c_nw = 0, d_busy = 0, c_busy = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int op, bit nw, int bsel, int len, int off);
    return {op[3:0], nw, bsel[1:0], len[8:0], off[15:0]};
  endfunction

  // Driver: load program and push the expected dispatches
  task automatic load_prog(logic [31:0] words[$]);
    for (int i = 0; i < 32; i++) prog[i] = (i < words.size()) ? words[i] : 32'hF000_0000;
    exp_q.delete();
    foreach (words[i]) begin
      automatic logic [31:0] w = words[i];
      automatic item_t it;
      automatic int op = int'(w[31:28]);
      automatic logic [31:0] base;
      if (op >= 7) break;
      case (w[26:25])
        2'd0: base = cfg_in_base;
        2'd1: base = cfg_out_base;
        2'd2: base = cfg_prog_base;
        default: base = 0;
      endcase
      it.is_dma = (op <= 1);
      it.wr = (op == 1);
      it.addr = base + {16'h0, w[15:0]};
      it.len = w[24:16];
      it.kind = 3'(op - 2);
      it.arg = w[15:0];
      it.blocking = !(w[27] && op != 1);
      exp_q.push_back(it);
    end
  endtask

  // Fetch responder
  bit f_rdy = 0; int f_wait = 0;
  always @(negedge clk) begin
    fetch_rsp_valid = 0;
    if (f_rdy) begin
      f_rdy = 0; fetch_ready = 0; f_wait = 0;
      chk(fetch_addr == exp_fetch, "R2", "fetch address", fetch_addr, exp_fetch);
      if (blk_out) blk_viol = 1;
      if (d_nw || c_nw) overlap_seen = 1;
      fetch_rsp_data = prog[(fetch_addr - cfg_prog_base) & 31];
      fetch_rsp_valid = 1;
      exp_fetch = exp_fetch + 1;
      fetch_count++;
    end else if (fetch_valid) begin
      if (f_wait >= fetch_lat) begin f_rdy = 1; fetch_ready = 1; end
      else f_wait++;
    end
  end

  task automatic sb_pop(bit is_dma_unit, output bit blocking);
    item_t e;
    blocking = 1;
    if (exp_q.size() == 0) begin
      chk(0, is_dma_unit ? "R4" : "R5", "unexpected dispatch", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    blocking = e.blocking;
    if (is_dma_unit) begin
      chk(e.is_dma, "R4", "unit is DMA", 1, e.is_dma);
      chk(dma_addr == e.addr, "R4", "dma_addr", dma_addr, e.addr);
      chk(dma_write == e.wr && dma_len == e.len, "R4", "dma_write/len",
          {dma_write, dma_len}, {e.wr, e.len});
    end else begin
      chk(!e.is_dma, "R5", "unit is compute", 0, e.is_dma);
      chk(cmp_kind == e.kind && cmp_arg == e.arg, "R5", "cmp_kind/arg",
          {cmp_kind, cmp_arg}, {e.kind, e.arg});
    end
  endtask

  // DMA responder (monitor side of the scoreboard)
  bit d_rdy = 0, d_seen = 0; int d_wait = 0, d_cnt = 0;
  logic [AW-1:0] d_cap_addr;
  always @(negedge clk) begin
    automatic bit blk;
    dma_done = 0;
    if (d_busy) begin
      if (d_cnt == 0) begin
        dma_done = 1; d_busy = 0; d_nw = 0;
        if (blk_out) begin
          chk(!blk_viol, "R6", "fetch during blocking DMA", blk_viol, 0);
          blk_out = 0; blk_viol = 0;
        end
      end else d_cnt--;
    end
    if (d_rdy) begin
      d_rdy = 0; dma_ready = 0; d_seen = 0; d_wait = 0;
      chk(dma_addr == d_cap_addr, "R3", "dma payload held", dma_addr, d_cap_addr);
      sb_pop(1, blk);
      if (blk) begin blk_out = 1; blk_viol = 0; end else d_nw = 1;
      d_busy = 1; d_cnt = dma_done_dly;
    end else if (dma_valid) begin
      if (d_busy) r7_viol = 1;
      if (!d_seen) begin d_seen = 1; d_cap_addr = dma_addr; end
      if (d_wait >= dma_rdy_dly) begin d_rdy = 1; dma_ready = 1; end
      else d_wait++;
    end
  end

  // Compute responder
  bit c_rdy = 0, c_seen = 0; int c_wait = 0, c_cnt = 0;
  logic [18:0] c_cap;
  always @(negedge clk) begin
    automatic bit blk;
    cmp_done = 0;
    if (c_busy) begin
      if (c_cnt == 0) begin
        cmp_done = 1; c_busy = 0; c_nw = 0;
        if (blk_out) begin
          chk(!blk_viol, "R6", "fetch during blocking compute", blk_viol, 0);
          blk_out = 0; blk_viol = 0;
        end
      end else c_cnt--;
    end
    if (c_rdy) begin
      c_rdy = 0; cmp_ready = 0; c_seen = 0; c_wait = 0;
      chk({cmp_kind, cmp_arg} == c_cap, "R3", "cmp payload held", {cmp_kind, cmp_arg}, c_cap);
      sb_pop(0, blk);
      if (blk) begin blk_out = 1; blk_viol = 0; end else c_nw = 1;
      c_busy = 1; c_cnt = cmp_done_dly;
    end else if (cmp_valid) begin
      if (c_busy) r7_viol = 1;
      if (!c_seen) begin c_seen = 1; c_cap = {cmp_kind, cmp_arg}; end
      if (c_wait >= cmp_rdy_dly) begin c_rdy = 1; cmp_ready = 1; end
      else c_wait++;
    end
  end

  // One run; returns busy-cycle count. mid_go pulses go while busy (R10).
  task automatic run(bit mid_go, output int cyc);
    int i;
    exp_fetch = cfg_prog_base; fetch_count = 0;
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    chk(busy == 1, "R2", "busy after go", busy, 1);
    cyc = 0; i = 0;
    while (busy && i < 5000) begin
      cyc++; i++;
      if (mid_go && i == 5) go = 1;
      if (mid_go && i == 6) go = 0;
      @(negedge clk);
    end
    go = 0;
    chk(!d_busy && !c_busy, "R8", "no done outstanding at end", {d_busy, c_busy}, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] p[$];
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, irq, err} == 0, "R1", "status after reset", {busy, irq, err}, 0);
    chk({fetch_valid, dma_valid, cmp_valid} == 0, "R1", "valids after reset",
        {fetch_valid, dma_valid, cmp_valid}, 0);
    chk(last_cycles == 0, "R1", "last_cycles after reset", last_cycles, 0);
    rst_n = 1;
    @(negedge clk);

    // Test 1: every opcode, blocking, back-pressure, mid-run go (R4 R5 R6 R8 R10 R11)
    fetch_lat = 1; dma_rdy_dly = 2; dma_done_dly = 3; cmp_rdy_dly = 1; cmp_done_dly = 2;
    p = '{mk(0,0,0,4,16'h0010), mk(2,0,0,0,16'h0101), mk(3,0,0,0,16'h0202),
          mk(4,0,0,0,16'h0303), mk(5,0,0,0,16'h0404), mk(6,0,0,0,16'h0505),
          mk(1,0,1,8,16'h0040), mk(0,0,2,2,16'h0100), mk(0,0,3,1,16'h7777),
          mk(7,0,0,0,0)};
    load_prog(p);
    run(1, cyc);
    chk(irq == 1 && err == 0, "R8", "irq after stop", {irq, err}, 2'b10);
    chk(last_cycles == cyc, "R11", "run length", last_cycles, cyc);
    chk(fetch_count == 10, "R10", "fetch count with mid-run go", fetch_count, 10);
    repeat (4) @(negedge clk);
    chk(busy == 0 && irq == 1, "R10", "no second run, irq held (R8)", {busy, irq}, 2'b01);
    chk(exp_q.size() == 0, "R4", "all dispatches seen", exp_q.size(), 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(irq == 0, "R8", "irq cleared", irq, 0);

    // Test 2: detached commands (R7)
    fetch_lat = 0; dma_rdy_dly = 0; dma_done_dly = 8; cmp_rdy_dly = 0; cmp_done_dly = 6;
    overlap_seen = 0; r7_viol = 0;
    p = '{mk(0,1,1,3,16'h0020), mk(2,1,0,0,16'h0005), mk(0,0,0,5,16'h0001),
          mk(1,1,2,7,16'h0030), mk(6,1,0,0,16'h0009), mk(5,0,0,0,16'h000A),
          mk(7,0,0,0,0)};
    load_prog(p);
    run(0, cyc);
    chk(overlap_seen, "R7", "fetch overlapped a detached command", overlap_seen, 1);
    chk(!r7_viol, "R7", "same unit held until done", r7_viol, 0);
    chk(irq == 1 && last_cycles == cyc, "R11", "detached run length", last_cycles, cyc);
    chk(exp_q.size() == 0, "R5", "all dispatches seen", exp_q.size(), 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;

    // Test 3: undefined opcode (R9)
    dma_done_dly = 1; cmp_done_dly = 1;
    p = '{mk(5,0,0,0,16'h0011), 32'hC000_0000, mk(0,0,0,1,0), mk(7,0,0,0,0)};
    load_prog(p);
    run(0, cyc);
    chk(err == 1 && irq == 0 && busy == 0, "R9", "halt on bad opcode", {err, irq, busy}, 3'b100);
    chk(fetch_count == 2, "R9", "no fetch after bad opcode", fetch_count, 2);
    chk(exp_q.size() == 0, "R9", "only first command dispatched", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(dma_valid == 0 && err == 1, "R9", "no dispatch, err held", {dma_valid, err}, 2'b01);

    // Test 4: next go clears err (R9), short run (R11)
    p = '{mk(0,0,1,1,16'h0002), mk(7,0,0,0,0)};
    load_prog(p);
    run(0, cyc);
    chk(err == 0 && irq == 1, "R9", "err cleared by go", {err, irq}, 2'b01);
    chk(last_cycles == cyc, "R11", "short run length", last_cycles, cyc);

    done_flag = 1;
    summary();
  end
endmodule